// File: doc/BRIEF.md
# Block-Transfer Host Register Interface

This block is the host-facing side of a block-transfer style management mailbox. A byte-wide host port reaches three registers at consecutive offsets: a control and status register, a data port and an interrupt mask register. The host fills an inbound request buffer through the data port and then rings the controller. The controller reads the request through a separate index port, places its answer into an outbound buffer and commits it with a load pulse. The host then drains the answer through the same data port.

Handshake flags are held in the control register. There is a busy bit for each side, one attention flag per direction and a message-attention flag that the controller sets and clears through dedicated inputs. Some control bits clear a flag when written with 1, one toggles and some trigger an action. A level-sensitive, active-high interrupt line follows the pending bit of the mask register. That pending bit depends on the attention flags and on edges of the enable bit. The inbound and outbound buffers are DEPTH bytes deep. The inbound byte counter is CNT_W bits wide.

Top module: `bt_host_regs`

## Requirements
- R1: Offset 0 reads the control register, laid out as {ctl_busy, host_busy, 0, msg_attn, rsp_attn, 0, 0, 0} from bit 7 down to bit 0. Offset 2 reads {6'b0, pending, enable}. Offset 3 reads 0xFF and a write to it changes nothing.
- R2: A write to offset 1 stores the byte at index in_len when in_len < DEPTH. in_len then increments whether or not the byte was stored, and it stops at 2**CNT_W-1.
- R3: Writing control bit 0 as 1 sets in_len to 0.
- R4: While the read position is below the outbound length, a read of offset 1 returns the byte at that position and advances the position. Taking the last byte sets both position and length to 0. With nothing pending the read returns 0xFF.
- R5: Writing control bit 1 as 1 returns the outbound read position to 0, so the response can be read again from its first byte.
- R6: Writing control bit 3 as 1 clears rsp_attn and writing control bit 4 as 1 clears msg_attn. Writing control bit 6 as 1 inverts host_busy.
- R7: Writing control bit 2 as 1 sets ctl_busy and makes req_strobe high for exactly the one cycle that follows the write.
- R8: A rsp_load pulse clears ctl_busy, sets rsp_attn and sets the outbound length to rsp_len with the position at 0. It also sets pending when enable is 1.
- R9: A mask write that takes enable from 0 to 1 sets pending if rsp_attn or msg_attn is set. A mask write that takes enable from 1 to 0 clears pending.
- R10: A mask write with bit 1 as 1 clears pending. This clear is applied after any enable change made by the same write.
- R11: attn_set raises msg_attn when it is clear, and sets pending if enable is 1 and rsp_attn is 0. attn_clr lowers msg_attn when it is set, and clears pending only when rsp_attn is 0.
- R12: Reset clears both buffer lengths, the read position, all flags, enable and pending.
- R13: irq is high exactly when the pending bit is set, and it changes only on a response load, on a message-attention event or on a mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; side effects at the clock edge |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the current offset |
| req_strobe | output | 1 | One-cycle request-ready pulse to the controller |
| in_len | output | CNT_W | Inbound byte count |
| in_rd_idx | input | $clog2(DEPTH) | Controller read index into the inbound buffer |
| in_rd_data | output | 8 | Inbound byte at in_rd_idx |
| rsp_wr | input | 1 | Write one outbound byte |
| rsp_idx | input | $clog2(DEPTH) | Outbound byte index |
| rsp_data | input | 8 | Outbound byte value |
| rsp_load | input | 1 | Commit the response |
| rsp_len | input | $clog2(DEPTH+1) | Response length, clamped to DEPTH |
| attn_set | input | 1 | Raise message attention |
| attn_clr | input | 1 | Lower message attention |
| irq | output | 1 | Level interrupt to the host, active high |

## Verification
The hardest cases to reach are the interrupt cases where an enable edge, a pending clear and the attention flags act in the same write or close together. One example is a mask write of 0x03 while an attention flag is up: it sets pending and then clears it at once. Another is message attention being dropped while a response attention still holds pending. The bench sweeps every combination of the two attention flags before each enable edge, and it builds each flag state through the normal ports (a response load for one flag, attn_set for the other). Inbound lengths are swept from empty to past the buffer depth and up to the counter limit, and outbound lengths from one byte to full depth.

// File: rtl/bt_host_pkg.sv
package bt_host_pkg;
  localparam logic [1:0] OFS_CTL  = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  localparam int CB_CLR_IN  = 0;
  localparam int CB_CLR_OUT = 1;
  localparam int CB_RING    = 2;
  localparam int CB_RSP_AT  = 3;
  localparam int CB_MSG_AT  = 4;
  localparam int CB_HBUSY   = 6;

  localparam int MB_EN   = 0;
  localparam int MB_PEND = 1;

  typedef struct packed {
    logic       mask_wr;
    logic [1:0] mask_val;
    logic       clr_rsp_at;
    logic       clr_msg_at;
    logic       rsp_load;
    logic       attn_set;
    logic       attn_clr;
  } irq_evt_t;
endpackage

// File: rtl/bt_inbound_buf.sv
module bt_inbound_buf #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             store_en;

  assign store_en = wr_en && (cnt_q < CNT_W'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (wr_en && (cnt_q != '1))
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (store_en) mem[cnt_q[IDX_W-1:0]] <= wr_data;
  end

  assign cnt     = cnt_q;
  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/bt_outbound_buf.sv
module bt_outbound_buf #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_wr,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             take,
  input  logic             rewind,
  output logic             avail,
  output logic [7:0]       head,
  output logic [LEN_W-1:0] pos,
  output logic [LEN_W-1:0] len
);
  logic [7:0]       mem [DEPTH];
  logic [LEN_W-1:0] pos_q, pos_d, len_q, len_d;

  assign avail = pos_q < len_q;

  always_comb begin
    pos_d = pos_q;
    len_d = len_q;
    if (rewind) begin
      pos_d = '0;
    end else if (take && avail) begin
      if (pos_q + LEN_W'(1) == len_q) begin
        pos_d = '0;
        len_d = '0;
      end else begin
        pos_d = pos_q + LEN_W'(1);
      end
    end
    if (load) begin
      pos_d = '0;
      len_d = (load_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : load_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= '0;
    end else begin
      pos_q <= pos_d;
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_wr) mem[ld_idx] <= ld_data;
  end

  assign head = mem[pos_q[IDX_W-1:0]];
  assign pos  = pos_q;
  assign len  = len_q;
endmodule

// File: rtl/bt_irq_ctrl.sv
module bt_irq_ctrl
  import bt_host_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_evt_t evt,
  output logic     rsp_at,
  output logic     msg_at,
  output logic     en,
  output logic     pend
);
  logic rsp_q, rsp_d, msg_q, msg_d, en_q, en_d, pend_q, pend_d;

  always_comb begin
    rsp_d  = rsp_q;
    msg_d  = msg_q;
    en_d   = en_q;
    pend_d = pend_q;
    // host side first
    if (evt.clr_rsp_at) rsp_d = 1'b0;
    if (evt.clr_msg_at) msg_d = 1'b0;
    if (evt.mask_wr) begin
      if (evt.mask_val[MB_EN] != en_d) begin
        if (evt.mask_val[MB_EN]) begin
          if (rsp_d || msg_d) pend_d = 1'b1;
          en_d = 1'b1;
        end else begin
          pend_d = 1'b0;
          en_d   = 1'b0;
        end
      end
      if (evt.mask_val[MB_PEND]) pend_d = 1'b0;
    end
    // controller side next
    if (evt.rsp_load) begin
      rsp_d = 1'b1;
      if (en_d) pend_d = 1'b1;
    end
    if (evt.attn_set && !evt.attn_clr && !msg_d) begin
      msg_d = 1'b1;
      if (en_d && !rsp_d) pend_d = 1'b1;
    end else if (evt.attn_clr && !evt.attn_set && msg_d) begin
      msg_d = 1'b0;
      if (!rsp_d) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q  <= 1'b0;
      msg_q  <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      rsp_q  <= rsp_d;
      msg_q  <= msg_d;
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign rsp_at = rsp_q;
  assign msg_at = msg_q;
  assign en     = en_q;
  assign pend   = pend_q;
endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs
  import bt_host_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             req_strobe,
  output logic [CNT_W-1:0] in_len,
  input  logic [IDX_W-1:0] in_rd_idx,
  output logic [7:0]       in_rd_data,
  input  logic             rsp_wr,
  input  logic [IDX_W-1:0] rsp_idx,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_load,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic             attn_set,
  input  logic             attn_clr,
  output logic             irq
);
  logic ctl_wr, data_wr, mask_wr, data_rd;
  logic bbusy_q, bbusy_d, hbusy_q, hbusy_d, req_q, req_d;
  logic out_avail;
  logic [7:0] out_head;
  logic [LEN_W-1:0] out_pos, out_len;
  logic rsp_at, msg_at, irq_en, irq_pend;
  irq_evt_t evt;
  logic unused_wbits;

  assign unused_wbits = ^{host_wdata[7], host_wdata[5]};

  assign ctl_wr  = host_wr && (host_addr == OFS_CTL);
  assign data_wr = host_wr && (host_addr == OFS_DATA);
  assign mask_wr = host_wr && (host_addr == OFS_MASK);
  assign data_rd = host_rd && (host_addr == OFS_DATA);

  bt_inbound_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_in (
    .clk(clk), .rst_n(rst_n),
    .wr_en(data_wr), .wr_data(host_wdata),
    .clr(ctl_wr && host_wdata[CB_CLR_IN]),
    .cnt(in_len), .rd_idx(in_rd_idx), .rd_data(in_rd_data)
  );

  bt_outbound_buf #(.DEPTH(DEPTH)) i_out (
    .clk(clk), .rst_n(rst_n),
    .ld_wr(rsp_wr), .ld_idx(rsp_idx), .ld_data(rsp_data),
    .load(rsp_load), .load_len(rsp_len),
    .take(data_rd), .rewind(ctl_wr && host_wdata[CB_CLR_OUT]),
    .avail(out_avail), .head(out_head), .pos(out_pos), .len(out_len)
  );

  always_comb begin
    evt            = '0;
    evt.mask_wr    = mask_wr;
    evt.mask_val   = host_wdata[1:0];
    evt.clr_rsp_at = ctl_wr && host_wdata[CB_RSP_AT];
    evt.clr_msg_at = ctl_wr && host_wdata[CB_MSG_AT];
    evt.rsp_load   = rsp_load;
    evt.attn_set   = attn_set;
    evt.attn_clr   = attn_clr;
  end

  bt_irq_ctrl i_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .rsp_at(rsp_at), .msg_at(msg_at), .en(irq_en), .pend(irq_pend)
  );

  always_comb begin
    hbusy_d = hbusy_q ^ (ctl_wr && host_wdata[CB_HBUSY]);
    req_d   = ctl_wr && host_wdata[CB_RING];
    bbusy_d = bbusy_q;
    if (req_d)    bbusy_d = 1'b1;
    if (rsp_load) bbusy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bbusy_q <= 1'b0;
      hbusy_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      bbusy_q <= bbusy_d;
      hbusy_q <= hbusy_d;
      req_q   <= req_d;
    end
  end

  always_comb begin
    unique case (host_addr)
      OFS_CTL:  host_rdata = {bbusy_q, hbusy_q, 1'b0, msg_at, rsp_at, 3'b000};
      OFS_DATA: host_rdata = out_avail ? out_head : 8'hFF;
      OFS_MASK: host_rdata = {6'b0, irq_pend, irq_en};
      default:  host_rdata = 8'hFF;
    endcase
  end

  assign req_strobe = req_q;
  assign irq        = irq_pend;
endmodule

// File: rtl/bt_host_regs_chk.sv
module bt_host_regs_chk #(
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       host_addr,
  input logic             host_wr,
  input logic [7:0]       host_wdata,
  input logic             rsp_load,
  input logic             attn_set,
  input logic             attn_clr,
  input logic             req_strobe,
  input logic             irq,
  input logic             bbusy,
  input logic             rsp_at,
  input logic             msg_at,
  input logic             irq_en,
  input logic [LEN_W-1:0] out_pos,
  input logic [LEN_W-1:0] out_len
);
  logic ring, mwr;
  assign ring = host_wr && (host_addr == 2'd0) && host_wdata[2];
  assign mwr  = host_wr && (host_addr == 2'd2);

  a_r7_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ring |=> req_strobe);
  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ring && !rsp_load) |=> bbusy);
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |=> (!bbusy && rsp_at));
  a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_load && irq_en && !mwr) |=> irq);
  a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr && !host_wdata[0]) |=> !irq);
  a_r4_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pos < out_len) || (out_pos == '0 && out_len == '0));
  a_r11_attn_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_set && !attn_clr && !msg_at && irq_en && !rsp_at && !mwr) |=> irq);
  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !rsp_load && !attn_set && !attn_clr && !mwr) |=> !irq);
endmodule

bind bt_host_regs bt_host_regs_chk #(.LEN_W(LEN_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .rsp_load(rsp_load), .attn_set(attn_set),
  .attn_clr(attn_clr), .req_strobe(req_strobe), .irq(irq), .bbusy(bbusy_q),
  .rsp_at(rsp_at), .msg_at(msg_at), .irq_en(irq_en),
  .out_pos(out_pos), .out_len(out_len)
);

// File: tb/test_bt_host_regs.sv
module test_bt_host_regs;
  localparam int DEPTH = 8;
  localparam int CNT_W = 5;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] host_addr;
  logic host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic req_strobe;
  logic [CNT_W-1:0] in_len;
  logic [IDX_W-1:0] in_rd_idx;
  logic [7:0] in_rd_data;
  logic rsp_wr;
  logic [IDX_W-1:0] rsp_idx;
  logic [7:0] rsp_data;
  logic rsp_load;
  logic [LEN_W-1:0] rsp_len;
  logic attn_set, attn_clr, irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bt_host_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_bt_host_regs (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic load_rsp(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_wr = 1'b1; rsp_idx = IDX_W'(i); rsp_data = 8'(base + i);
    end
    @(negedge clk);
    rsp_wr = 1'b0; rsp_load = 1'b1; rsp_len = LEN_W'(n);
    @(negedge clk);
    rsp_load = 1'b0;
  endtask

  task automatic pulse_set();
    @(negedge clk); attn_set = 1'b1;
    @(negedge clk); attn_set = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); attn_clr = 1'b1;
    @(negedge clk); attn_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    in_rd_idx = '0; rsp_wr = 0; rsp_idx = '0; rsp_data = '0;
    rsp_load = 0; rsp_len = '0; attn_set = 0; attn_clr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 / R1 reset state
    rd(2'd0, d); chk("R12 ctl reset", d, 8'h00);
    rd(2'd2, d); chk("R12 mask reset", d, 8'h00);
    chk("R12 irq reset", irq, 0);
    chk("R12 in_len reset", in_len, 0);
    rd(2'd1, d); chk("R4 empty read", d, 8'hFF);
    rd(2'd3, d); chk("R1 offset3 read", d, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd0, d); chk("R1 offset3 write no effect ctl", d, 8'h00);
    rd(2'd2, d); chk("R1 offset3 write no effect mask", d, 8'h00);

    // R2 / R3 inbound sweep
    for (int n = 0; n <= DEPTH + 4; n++) begin
      wr(2'd0, 8'h01);
      for (int i = 0; i < n; i++) wr(2'd1, 8'((n * 16 + i) ^ 8'h5A));
      chk("R2 in_len count", in_len, n);
      for (int i = 0; i < n && i < DEPTH; i++) begin
        in_rd_idx = IDX_W'(i);
        #1 chk("R2 stored byte", in_rd_data, 8'((n * 16 + i) ^ 8'h5A));
      end
      if (n > DEPTH) begin
        in_rd_idx = IDX_W'(DEPTH - 1);
        #1 chk("R2 overflow dropped", in_rd_data, 8'((n * 16 + DEPTH - 1) ^ 8'h5A));
      end
    end
    wr(2'd0, 8'h01);
    for (int i = 0; i < (1 << CNT_W) + 3; i++) wr(2'd1, 8'h11);
    chk("R2 counter saturates", in_len, (1 << CNT_W) - 1);
    wr(2'd0, 8'h01);
    chk("R3 clear write pointer", in_len, 0);

    // R7 ring
    @(negedge clk);
    host_addr = 2'd0; host_wdata = 8'h04; host_wr = 1'b1;
    #1 chk("R7 no strobe before edge", req_strobe, 0);
    @(negedge clk);
    host_wr = 1'b0;
    chk("R7 strobe high", req_strobe, 1);
    @(negedge clk);
    chk("R7 strobe one cycle", req_strobe, 0);
    rd(2'd0, d); chk("R7 ctl busy set", d, 8'h80);

    // R6 host busy toggle
    wr(2'd0, 8'h40); rd(2'd0, d); chk("R6 hbusy toggled on", d, 8'hC0);
    wr(2'd0, 8'h40); rd(2'd0, d); chk("R6 hbusy toggled off", d, 8'h80);

    // R8 / R4 outbound sweep, interrupts disabled
    for (int n = 1; n <= DEPTH; n++) begin
      wr(2'd0, 8'h04);
      load_rsp(n, n * 8 + 8'h30);
      rd(2'd0, d); chk("R8 ctl after load", d, 8'h08);
      chk("R8 no irq when disabled", irq, 0);
      for (int i = 0; i < n; i++) begin
        rd(2'd1, d); chk("R4 outbound byte", d, 8'(n * 8 + 8'h30 + i));
      end
      rd(2'd1, d); chk("R4 drained reads FF", d, 8'hFF);
      wr(2'd0, 8'h08);
      rd(2'd0, d); chk("R6 rsp attention cleared", d, 8'h00);
    end

    // R5 rewind
    load_rsp(4, 8'hA0);
    rd(2'd1, d); rd(2'd1, d);
    wr(2'd0, 8'h02);
    for (int i = 0; i < 4; i++) begin
      rd(2'd1, d); chk("R5 reread after rewind", d, 8'hA0 + 8'(i));
    end
    rd(2'd1, d); chk("R5 drained after rewind", d, 8'hFF);

    // R9 enable edges over all attention combinations
    for (int r = 0; r < 2; r++) begin
      for (int m = 0; m < 2; m++) begin
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h18);
        if (r == 1) begin load_rsp(1, 8'h77); rd(2'd1, d); end
        if (m == 1) pulse_set();
        chk("R9 irq low before enable", irq, 0);
        wr(2'd2, 8'h01);
        rd(2'd2, d); chk("R9 enable rise pending", d, {6'b0, 1'(r | m), 1'b1});
        chk("R13 irq follows pending", irq, r | m);
        wr(2'd2, 8'h00);
        rd(2'd2, d); chk("R9 enable fall clears", d, 8'h00);
        chk("R13 irq low after disable", irq, 0);
        wr(2'd2, 8'h03);
        rd(2'd2, d); chk("R10 enable and clear same write", d, 8'h01);
        chk("R10 irq low", irq, 0);
        wr(2'd2, 8'h00);
      end
    end

    // R8 / R10 interrupt on load
    wr(2'd0, 8'h18);
    wr(2'd2, 8'h01);
    chk("R9 no pending without attention", irq, 0);
    load_rsp(2, 8'h10);
    chk("R8 irq on load", irq, 1);
    load_rsp(2, 8'h20);
    rd(2'd2, d); chk("R8 second load keeps pending", d, 8'h03);
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R10 bit1 zero keeps pending", d, 8'h03);
    wr(2'd2, 8'h03);
    rd(2'd2, d); chk("R10 clear pending", d, 8'h01);
    chk("R10 irq dropped", irq, 0);
    wr(2'd2, 8'h03);
    rd(2'd2, d); chk("R10 clear when idle", d, 8'h01);

    // R11 message attention
    wr(2'd0, 8'h1A);
    pulse_set();
    chk("R11 set raises irq", irq, 1);
    rd(2'd0, d); chk("R11 msg flag set", d, 8'h10);
    pulse_clr();
    chk("R11 clear drops irq", irq, 0);
    rd(2'd0, d); chk("R11 msg flag cleared", d, 8'h00);
    load_rsp(1, 8'h00);
    wr(2'd2, 8'h03);
    pulse_set();
    chk("R11 no irq while rsp attention", irq, 0);
    pulse_clr();
    wr(2'd0, 8'h00);
    load_rsp(1, 8'h00);
    pulse_set();
    pulse_clr();
    chk("R11 clear keeps pending with rsp attention", irq, 1);
    wr(2'd0, 8'h10);
    pulse_set();
    wr(2'd0, 8'h10);
    rd(2'd0, d); chk("R6 msg attention cleared by host", d, 8'h08);
    chk("R13 host clear leaves irq", irq, 1);

    // R12 reset during activity
    wr(2'd0, 8'h40);
    do_reset();
    rd(2'd2, d); chk("R12 mask after reset", d, 8'h00);
    chk("R12 irq after reset", irq, 0);
    rd(2'd0, d); chk("R12 ctl after reset", d, 8'h00);
    rd(2'd1, d); chk("R12 outbound empty after reset", d, 8'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule